// File: doc/BRIEF.md
# Bus Tenure Arbiter

This block shares one bus among several masters. Each master raises a request line and holds it for as long as it wants the bus. The arbiter answers with a one-hot grant. The winner keeps the bus until it lowers its request or until its tenure, a cycle budget given on an input, runs out. Every handover leaves exactly one idle cycle on the bus. The arbiter picks the next owner in the cycle after that idle cycle begins.

Fixed priority favours the lowest master index. To stop low-priority masters from waiting forever, every waiting master carries an age counter. A master whose age has reached a threshold is served ahead of fixed priority. A master cut off by the tenure budget stays locked out until it lowers its request once. A long burst therefore cannot reclaim the bus straight away. The arbiter reports the current owner as an index with a valid flag, and marks the last cycle of a tenure on each master's grant.

Top module: `bus_tenure_arbiter`

## Requirements
- R1: While reset is high and in the first cycle after it, no grant is asserted, owner_valid is 0 and all age counters are zero.
- R2: The grant vector has at most one bit set. When no master owns the bus and no request is present, the next cycle carries no grant.
- R3: When the bus is free, the next grant goes to the lowest-indexed eligible requester, unless an aged master is waiting. Index 0 has the highest priority. A requester is eligible when it is not locked out.
- R4: An owner keeps its grant, with owner_idx unchanged, for as long as its request stays high within its budget. If the owner's request is low at a clock edge, the grant is gone after that edge.
- R5: One grant lasts at most L cycles, where L is tenure_limit, with a value of 0 treated as 1. A master that requests continuously is granted for exactly L cycles.
- R6: A master whose tenure expired while it still requested is not eligible until it lowers its request for at least one cycle.
- R7: Between two owners, and between two grants to the same owner, the bus is idle for exactly one cycle when an eligible requester is waiting.
- R8: The age counter of an eligible master that does not own the bus rises by one each cycle, saturating at AGE_MAX. Eligible masters at AGE_MAX win over fixed priority, the lowest index among them first. A low-priority master facing busy higher-priority masters is therefore eventually granted.
- R9: A master's age counter is cleared only in the cycle it is granted. When the master lowers its request, or is locked out, the age holds its value.
- R10: gnt_last[i] is high exactly in the final cycle of a tenure that ends by budget expiry, that is, when master i owns the bus and has held it for L cycles.
- R11: owner_valid is high exactly when a grant is asserted, and owner_idx then names the granted master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | N | Request line per master, held while the bus is wanted |
| tenure_limit | input | TEN_W | Tenure budget in cycles, 0 acts as 1 |
| gnt | output | N | One-hot grant, registered |
| gnt_last | output | N | Marks the final budget cycle on the owner's grant |
| owner_idx | output | IDX_W | Index of the current owner |
| owner_valid | output | 1 | A master owns the bus |

## Verification
Grants, owner_idx and owner_valid are registered. A request pattern present before an edge is reflected in them just after that edge, one cycle later. gnt_last is combinational from the owned-cycle count and tenure_limit, so it shows in the same cycle as the grant state it describes. The bench drives inputs shortly after each falling edge and pushes the expected post-edge outputs into a queue. A monitor pops one item at the following falling edge, when the registers have settled and before any new input is applied. tenure_limit changes only while the bus is idle, so that every grant runs under a single budget.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic {
        PH_OPEN = 1'b0,
        PH_HELD = 1'b1
    } arb_phase_e;

    localparam int unsigned ARB_POOL_W = 32;

    function automatic int unsigned lowest_set(input logic [ARB_POOL_W-1:0] v);
        int unsigned r;
        r = 0;
        for (int i = ARB_POOL_W - 1; i >= 0; i--) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/arb_age_bank.sv
module arb_age_bank #(
    parameter int unsigned N       = 4,
    parameter int unsigned AGE_MAX = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] elig,
    input  logic [N-1:0] holder,
    input  logic [N-1:0] clr,
    output logic [N-1:0] aged
);
    localparam int unsigned AGE_W = $clog2(AGE_MAX + 1);

    for (genvar i = 0; i < N; i++) begin : g_age
        logic [AGE_W-1:0] age_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                age_q <= '0;
            end else if (clr[i]) begin
                age_q <= '0;
            end else if (elig[i] && !holder[i] && age_q != AGE_W'(AGE_MAX)) begin
                age_q <= age_q + 1'b1;
            end
        end

        assign aged[i] = elig[i] && (age_q == AGE_W'(AGE_MAX));
    end
endmodule

// File: rtl/arb_pick.sv
module arb_pick
    import arb_pkg::*;
#(
    parameter int unsigned N     = 4,
    parameter int unsigned IDX_W = 2
) (
    input  logic [N-1:0]     elig,
    input  logic [N-1:0]     aged,
    output logic             any,
    output logic [IDX_W-1:0] win
);
    logic [ARB_POOL_W-1:0] pool;

    always_comb begin
        pool        = '0;
        pool[N-1:0] = (aged != '0) ? aged : elig;
        any         = (elig != '0);
        win         = IDX_W'(lowest_set(pool));
    end
endmodule

// File: rtl/arb_owner.sv
module arb_owner
    import arb_pkg::*;
#(
    parameter int unsigned N     = 4,
    parameter int unsigned IDX_W = 2,
    parameter int unsigned TEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req,
    input  logic             any,
    input  logic [IDX_W-1:0] win,
    input  logic [TEN_W-1:0] limit,
    output logic             held,
    output logic [IDX_W-1:0] idx,
    output logic             at_end,
    output logic [N-1:0]     locked,
    output logic [N-1:0]     grant_now
);
    arb_phase_e       phase_q;
    logic [TEN_W-1:0] cnt_q;
    logic [TEN_W-1:0] eff_lim;
    logic             release_now;

    always_comb begin
        eff_lim     = (limit == '0) ? TEN_W'(1) : limit;
        held        = (phase_q == PH_HELD);
        at_end      = held && (cnt_q >= eff_lim - TEN_W'(1));
        release_now = held && (!req[idx] || at_end);
        grant_now   = '0;
        if (!held && any) grant_now[win] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_OPEN;
            idx     <= '0;
            cnt_q   <= '0;
        end else if (held) begin
            if (release_now) phase_q <= PH_OPEN;
            else             cnt_q   <= cnt_q + 1'b1;
        end else if (any) begin
            phase_q <= PH_HELD;
            idx     <= win;
            cnt_q   <= '0;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_lock
        always_ff @(posedge clk) begin
            if (rst) begin
                locked[i] <= 1'b0;
            end else if (!req[i]) begin
                locked[i] <= 1'b0;
            end else if (at_end && idx == IDX_W'(i)) begin
                locked[i] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/bus_tenure_arbiter.sv
module bus_tenure_arbiter #(
    parameter int unsigned N       = 4,
    parameter int unsigned TEN_W   = 8,
    parameter int unsigned AGE_MAX = 8,
    localparam int unsigned IDX_W  = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req,
    input  logic [TEN_W-1:0] tenure_limit,
    output logic [N-1:0]     gnt,
    output logic [N-1:0]     gnt_last,
    output logic [IDX_W-1:0] owner_idx,
    output logic             owner_valid
);
    logic [N-1:0]     locked;
    logic [N-1:0]     elig;
    logic [N-1:0]     aged;
    logic [N-1:0]     grant_now;
    logic             any;
    logic [IDX_W-1:0] win;
    logic             at_end;

    always_comb begin
        elig = req & ~locked;
        gnt  = '0;
        if (owner_valid) gnt[owner_idx] = 1'b1;
        gnt_last = at_end ? gnt : '0;
    end

    arb_age_bank #(.N(N), .AGE_MAX(AGE_MAX)) u_age (
        .clk(clk), .rst(rst), .elig(elig), .holder(gnt),
        .clr(grant_now), .aged(aged)
    );

    arb_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
        .elig(elig), .aged(aged), .any(any), .win(win)
    );

    arb_owner #(.N(N), .IDX_W(IDX_W), .TEN_W(TEN_W)) u_own (
        .clk(clk), .rst(rst), .req(req), .any(any), .win(win),
        .limit(tenure_limit), .held(owner_valid), .idx(owner_idx),
        .at_end(at_end), .locked(locked), .grant_now(grant_now)
    );
endmodule

// File: rtl/bus_tenure_arbiter_chk.sv
module bus_tenure_arbiter_chk #(
    parameter int unsigned N      = 4,
    parameter int unsigned TEN_W  = 8,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic [N-1:0]     req,
    input logic [TEN_W-1:0] tenure_limit,
    input logic [N-1:0]     gnt,
    input logic [N-1:0]     gnt_last,
    input logic [IDX_W-1:0] owner_idx,
    input logic             owner_valid
);
    logic [TEN_W:0] run_len;
    logic [TEN_W:0] lim_eff;

    assign lim_eff = (tenure_limit == '0) ? (TEN_W+1)'(1) : {1'b0, tenure_limit};

    always_ff @(posedge clk) begin
        if (rst)              run_len <= '0;
        else if (owner_valid) run_len <= run_len + 1'b1;
        else                  run_len <= '0;
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt)); // R2
    AST_IDLE_NO_GNT: assert property (@(posedge clk) disable iff (rst)
        (!owner_valid && req == '0) |=> (gnt == '0)); // R2
    AST_GRANT_TO_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(owner_valid) |-> (($past(req) & gnt) != '0)); // R3
    AST_DROP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (owner_valid && !req[owner_idx]) |=> !owner_valid); // R4
    AST_TENURE_CAP: assert property (@(posedge clk) disable iff (rst)
        owner_valid |-> (run_len < lim_eff)); // R5
    AST_LAST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (owner_valid && gnt_last[owner_idx]) |=> !owner_valid); // R10
    AST_NO_HANDOVER: assert property (@(posedge clk) disable iff (rst)
        (owner_valid && $past(owner_valid)) |-> $stable(owner_idx)); // R7
    AST_VALID_MATCH: assert property (@(posedge clk) disable iff (rst)
        owner_valid == (gnt != '0)); // R11
    AST_IDX_MATCH: assert property (@(posedge clk) disable iff (rst)
        owner_valid |-> gnt[owner_idx]); // R11
endmodule

bind bus_tenure_arbiter bus_tenure_arbiter_chk #(.N(N), .TEN_W(TEN_W)) u_chk (.*);

// File: tb/sim_bus_tenure_arbiter.sv
`timescale 1ns/1ps
module sim_bus_tenure_arbiter;
    localparam int NM   = 4;
    localparam int TW   = 8;
    localparam int AMAX = 8;

    typedef struct {
        logic [NM-1:0] gnt;
        logic [NM-1:0] last;
        logic [1:0]    idx;
        logic          v;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NM-1:0] req = '0;
    logic [TW-1:0] lim = 8'd4;
    logic [NM-1:0] gnt, gnt_last;
    logic [1:0]    owner_idx;
    logic          owner_valid;

    int   tests = 0;
    int   fails = 0;
    bit   done  = 0;
    bit   watch3 = 0;
    bit   seen3  = 0;
    exp_t q[$];

    int m_age[NM];
    bit m_blk[NM];
    bit m_v;
    int m_own;
    int m_cnt;

    always #5 clk = ~clk;

    bus_tenure_arbiter #(.N(NM), .TEN_W(TW), .AGE_MAX(AMAX)) u0 (
        .clk(clk), .rst(rst), .req(req), .tenure_limit(lim),
        .gnt(gnt), .gnt_last(gnt_last), .owner_idx(owner_idx),
        .owner_valid(owner_valid)
    );

    task automatic fail_msg(input string tag, input string what,
                            input logic [7:0] act, input logic [7:0] expv);
        fails++;
        $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    endtask

    // expected state after the coming edge, from the requirement rules
    task automatic model(input logic [NM-1:0] r, input logic [TW-1:0] l, input string tag);
        int  eff, win, nc, no;
        bit  nv, ending;
        bit  el[NM];
        exp_t e;
        eff = (l == 0) ? 1 : int'(l);
        win = -1;
        for (int i = 0; i < NM; i++) el[i] = r[i] && !m_blk[i];
        for (int i = NM - 1; i >= 0; i--) if (el[i] && m_age[i] == AMAX) win = i;
        if (win < 0) for (int i = NM - 1; i >= 0; i--) if (el[i]) win = i;
        ending = m_v && (m_cnt >= eff - 1);
        nv = m_v; no = m_own; nc = m_cnt;
        if (m_v) begin
            if (!r[m_own] || ending) nv = 0;
            else nc = m_cnt + 1;
        end else if (win >= 0) begin
            nv = 1; no = win; nc = 0;
        end
        for (int i = 0; i < NM; i++) begin
            if (!m_v && win == i) m_age[i] = 0;
            else if (el[i] && !(m_v && m_own == i) && m_age[i] < AMAX) m_age[i]++;
            if (!r[i]) m_blk[i] = 0;
            else if (ending && m_own == i) m_blk[i] = 1;
        end
        m_v = nv; m_own = no; m_cnt = nc;
        e.gnt  = m_v ? NM'(1 << m_own) : '0;
        e.last = (m_v && m_cnt >= eff - 1) ? e.gnt : '0;
        e.idx  = m_v ? 2'(m_own) : 2'(0);
        e.v    = m_v;
        e.tag  = tag;
        q.push_back(e);
    endtask

    task automatic step(input logic [NM-1:0] r, input logic [TW-1:0] l, input string tag);
        @(negedge clk);
        #2;
        req = r;
        lim = l;
        model(r, l, tag);
    endtask

    task automatic settle(input logic [TW-1:0] nl, input string tag);
        step('0, lim, tag);
        step('0, nl, tag);
    endtask

    // monitor: one expected item per cycle, compared at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (watch3 && gnt[3]) seen3 = 1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                tests++;
                if (gnt !== e.gnt || gnt_last !== e.last || owner_valid !== e.v ||
                    (e.v && owner_idx !== e.idx)) begin
                    fails++;
                    $display("FAIL %s gnt/last/valid/idx actual=%h/%h/%b/%0d expected=%h/%h/%b/%0d",
                             e.tag, gnt, gnt_last, owner_valid, owner_idx,
                             e.gnt, e.last, e.v, e.idx);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < NM; i++) begin m_age[i] = 0; m_blk[i] = 0; end
        m_v = 0; m_own = 0; m_cnt = 0;
        repeat (3) @(negedge clk);
        tests++; // R1 during reset
        if (gnt !== '0 || owner_valid !== 1'b0)
            fail_msg("R1", "reset gnt", {3'b0, owner_valid, gnt}, 8'h0);
        @(negedge clk);
        #2;
        rst = 1'b0;
        req = 4'b0110;
        @(negedge clk);
        tests++; // R1: request raised with release, first grant not earlier than this edge
        if (gnt !== 4'b0010) fail_msg("R1", "first grant", {4'b0, gnt}, 8'h02);
        req = '0;
        @(negedge clk);
        #2;
        // resync the model: m1 held 1 cycle, dropped; ages of m2 was 1 on that edge
        m_v = 0; m_own = 1; m_cnt = 0; m_age[2] = 1;
        q.delete();

        settle(8'd10, "R2");
        repeat (4) step('0, 8'd10, "R2");

        repeat (3) step(4'b1110, 8'd10, "R3");
        settle(8'd10, "R3");

        repeat (4) step(4'b0100, 8'd10, "R4");
        repeat (2) step(4'b0000, 8'd10, "R4");

        repeat (2) step(4'b0011, 8'd10, "R7");
        repeat (5) step(4'b0010, 8'd10, "R7");
        settle(8'd3, "R7");

        repeat (6) step(4'b0100, 8'd3, "R5");
        settle(8'd0, "R5");
        repeat (4) step(4'b0010, 8'd0, "R5");
        settle(8'd2, "R10");
        repeat (5) step(4'b1000, 8'd2, "R10");

        repeat (8) step(4'b0010, 8'd2, "R6");
        step(4'b0000, 8'd2, "R6");
        repeat (4) step(4'b0010, 8'd2, "R6");
        settle(8'd4, "R9");

        repeat (4) step(4'b1001, 8'd4, "R9");
        repeat (3) step(4'b0001, 8'd4, "R9");
        repeat (6) step(4'b1101, 8'd4, "R9");
        settle(8'd3, "R8");

        watch3 = 1;
        for (int k = 0; k < 60; k++)
            step({1'b1, 1'b0, (k % 5) != 4, (k % 4) != 3}, 8'd3, "R8");
        @(negedge clk);
        watch3 = 0;
        tests++; // R8: low-priority master reached the bus
        if (!seen3) fail_msg("R8", "master3 granted", 8'h0, 8'h1);
        settle(8'd3, "R11");

        lfsr = 16'hACE1;
        for (int k = 0; k < 200; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[3:0] | lfsr[7:4], 8'd3, "R11");
        end
        settle(8'd3, "R11");
        repeat (2) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule